// File: doc/BRIEF.md
# Nested-Loop Address Walker with Edge Padding

This block sequences the read addresses for one memory-to-stream DMA channel. It walks a buffer as four nested loops. Each loop level has its own element count and its own address stride. On top of that four-level pattern, a repeat count replays the whole walk several times, and each replay is shifted by a fixed address offset. The result is a five-level access pattern. All addresses are in units of 32-bit words, which matches the width of the outgoing stream.

The three innermost levels can also be framed with empty positions, placed before and after the real elements of that level. At such a position the walker raises a pad flag instead of naming a memory word. The stream datapath then sends zeros there and makes no read. The two directions of a level can be padded by different amounts.

A one-cycle start pulse captures the whole pattern description while the block is idle. The walker then presents one step at a time on a valid/ready output and holds a busy flag until the consumer accepts the step that carries the last flag.

Top module: `dag_walker`

## Requirements
- R1: After reset, `busy` and `out_valid` are low. They stay low until `start` is pulsed.
- R2: A `start` pulse while idle captures every configuration input. In the next cycle `busy` and `out_valid` are high, and the first step corresponds to index zero on every level.
- R3: Level 0 is the innermost loop. Each accepted data step on level 0 moves the address by `stride[0]` (bits 19:0 of the stride bus), counted modulo 2^20 in 32-bit word units.
- R4: When a level has walked all of its positions, its index returns to zero and its address contribution returns to zero. The next outer level (levels 0 to 3 from inner to outer, stride/count field d at bit d*width of its bus) then advances once by its own stride.
- R5: After a complete four-level pass, the base address grows by `iter_offset`. The walk is replayed until `iter_count` passes (count of 1 or more) have been produced.
- R6: Level d (d = 0, 1, 2) walks `pad_before[d] + wrap[d] + pad_after[d]` positions (each pad field 4 bits at bit d*4). The first `pad_before[d]` and the last `pad_after[d]` positions are padding. Level 3 has no padding.
- R7: A step is a pad step (`out_pad` = 1) exactly when any of levels 0 to 2 is at a padding position. A data step carries the address `base + pass*iter_offset + sum over d of (i_d - pad_before[d])*stride[d]`, where i_d is the position index of level d and pad_before of level 3 is zero.
- R8: `out_last` is high together with the final step of the final pass, and only then. It is never high without `out_valid`.
- R9: While `out_valid` is high and `out_ready` is low, `out_addr`, `out_pad` and `out_last` hold their values. The walk advances only on a cycle where valid and ready are both high.
- R10: `busy` drops in the cycle after the last step is accepted. A `start` pulse while busy is ignored: the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture configuration and begin walking (ignored while busy) |
| base_addr | input | 20 | Word address of element zero of the first pass |
| stride | input | 80 | Four 20-bit strides, level d at bits d*20+19:d*20 |
| wrap | input | 40 | Four 10-bit element counts (1 or more), level d at bits d*10+9:d*10 |
| pad_before | input | 12 | Three 4-bit leading pad counts, level d at bits d*4+3:d*4 |
| pad_after | input | 12 | Three 4-bit trailing pad counts, level d at bits d*4+3:d*4 |
| iter_count | input | 8 | Number of passes (1 or more) |
| iter_offset | input | 20 | Base address increment per pass |
| busy | output | 1 | Walk in progress |
| out_valid | output | 1 | A step is presented |
| out_ready | input | 1 | Consumer accepts the presented step |
| out_addr | output | 20 | Word address of the step (meaningful when out_pad is low) |
| out_pad | output | 1 | Step is a zero-padding position |
| out_last | output | 1 | Step is the final one of the transfer |

## Verification
A level counter that wraps one position early or late changes the number of steps per pass. The scoreboard then sees a shifted address or pad flag at the first wrap of that level, which is within a few accepted steps. A stride or pass offset that is accumulated wrongly corrupts the address of the first data step after the faulty update. A wrong pad boundary shows up as a flipped `out_pad` at the edge of the padded range. A broken hold or completion path shows at once: the payload changes during a stalled cycle, `busy` stays high after the final handshake, or the queue of expected steps is left non-empty.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int unsigned NUM_DIMS     = 4;
  localparam int unsigned NUM_PAD_DIMS = 3;
  localparam int unsigned OUTER_DIM    = NUM_DIMS - 1;
endpackage

// File: rtl/dag_dim_counter.sv
module dag_dim_counter #(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned PAD_W   = 4,
  parameter bit          HAS_PAD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CNT_W-1:0]  wrap_cnt,
  input  logic [ADDR_W-1:0] stride,
  input  logic [PAD_W-1:0]  pad_lo,
  input  logic [PAD_W-1:0]  pad_hi,
  input  logic              step,
  output logic              at_end,
  output logic              in_pad,
  output logic [ADDR_W-1:0] offset
);
  localparam int unsigned POS_W = CNT_W + 2;

  logic [CNT_W-1:0]  wrap_q,   wrap_d;
  logic [ADDR_W-1:0] stride_q, stride_d;
  logic [PAD_W-1:0]  lo_q,     lo_d;
  logic [PAD_W-1:0]  hi_q,     hi_d;
  logic [POS_W-1:0]  pos_q,    pos_d;
  logic [ADDR_W-1:0] acc_q,    acc_d;

  logic [POS_W-1:0]  lo_ext;
  logic [POS_W-1:0]  data_end;
  logic [POS_W-1:0]  last_pos;
  logic              past_lead;

  // Window boundaries of this level in position units
  always_comb begin
    lo_ext    = {{(POS_W-PAD_W){1'b0}}, lo_q};
    data_end  = lo_ext + {{(POS_W-CNT_W){1'b0}}, wrap_q};
    last_pos  = data_end + {{(POS_W-PAD_W){1'b0}}, hi_q} - {{(POS_W-1){1'b0}}, 1'b1};
    past_lead = (pos_q >= lo_ext);
    at_end    = (pos_q == last_pos);
    in_pad    = !past_lead || (pos_q >= data_end);
    offset    = acc_q;
  end

  // Next state: configuration capture and position/offset stepping
  always_comb begin
    wrap_d   = wrap_q;
    stride_d = stride_q;
    lo_d     = lo_q;
    hi_d     = hi_q;
    pos_d    = pos_q;
    acc_d    = acc_q;
    if (load) begin
      wrap_d   = wrap_cnt;
      stride_d = stride;
      lo_d     = HAS_PAD ? pad_lo : '0;
      hi_d     = HAS_PAD ? pad_hi : '0;
      pos_d    = '0;
      acc_d    = '0;
    end else if (step) begin
      if (at_end) begin
        pos_d = '0;
        acc_d = '0;
      end else begin
        pos_d = pos_q + {{(POS_W-1){1'b0}}, 1'b1};
        if (past_lead) begin
          acc_d = acc_q + stride_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrap_q   <= '0;
      stride_q <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      pos_q    <= '0;
      acc_q    <= '0;
    end else begin
      wrap_q   <= wrap_d;
      stride_q <= stride_d;
      lo_q     <= lo_d;
      hi_q     <= hi_d;
      pos_q    <= pos_d;
      acc_q    <= acc_d;
    end
  end
endmodule

// File: rtl/dag_iter_ctrl.sv
module dag_iter_ctrl #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned ITER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] offset_in,
  input  logic [ITER_W-1:0] count_in,
  input  logic              pass_done,
  output logic [ADDR_W-1:0] pass_base,
  output logic              last_pass
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] ioff_q, ioff_d;
  logic [ITER_W-1:0] cnt_q,  cnt_d;
  logic [ITER_W-1:0] idx_q,  idx_d;

  always_comb begin
    pass_base = base_q;
    last_pass = (idx_q + {{(ITER_W-1){1'b0}}, 1'b1}) >= cnt_q;
  end

  always_comb begin
    base_d = base_q;
    ioff_d = ioff_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    if (load) begin
      base_d = base_in;
      ioff_d = offset_in;
      cnt_d  = count_in;
      idx_d  = '0;
    end else if (pass_done) begin
      base_d = base_q + ioff_q;
      idx_d  = idx_q + {{(ITER_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ioff_q <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
    end else begin
      base_q <= base_d;
      ioff_q <= ioff_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
    end
  end
endmodule

// File: rtl/dag_walker.sv
module dag_walker #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned PAD_W  = 4,
  parameter int unsigned ITER_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  start,
  input  logic [ADDR_W-1:0]                     base_addr,
  input  logic [dag_pkg::NUM_DIMS*ADDR_W-1:0]   stride,
  input  logic [dag_pkg::NUM_DIMS*CNT_W-1:0]    wrap,
  input  logic [dag_pkg::NUM_PAD_DIMS*PAD_W-1:0] pad_before,
  input  logic [dag_pkg::NUM_PAD_DIMS*PAD_W-1:0] pad_after,
  input  logic [ITER_W-1:0]                     iter_count,
  input  logic [ADDR_W-1:0]                     iter_offset,
  output logic                                  busy,
  output logic                                  out_valid,
  input  logic                                  out_ready,
  output logic [ADDR_W-1:0]                     out_addr,
  output logic                                  out_pad,
  output logic                                  out_last
);
  import dag_pkg::*;

  logic                busy_q, busy_d;
  logic                load;
  logic                fire;
  logic [NUM_DIMS:0]   step_chain;
  logic [NUM_DIMS-1:0] dim_end;
  logic [NUM_DIMS-1:0] dim_pad;
  logic [ADDR_W-1:0]   dim_off [NUM_DIMS];
  logic [ADDR_W-1:0]   pass_base;
  logic                last_pass;
  logic                pass_done;

  assign load          = start && !busy_q;
  assign fire          = busy_q && out_ready;
  assign step_chain[0] = fire;
  assign pass_done     = step_chain[NUM_DIMS];

  for (genvar d = 0; d < NUM_DIMS; d++) begin : g_dim
    assign step_chain[d+1] = step_chain[d] && dim_end[d];
    if (d < NUM_PAD_DIMS) begin : g_pad
      dag_dim_counter #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .PAD_W  (PAD_W),
        .HAS_PAD(1'b1)
      ) u_dim (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .wrap_cnt(wrap[d*CNT_W +: CNT_W]),
        .stride  (stride[d*ADDR_W +: ADDR_W]),
        .pad_lo  (pad_before[d*PAD_W +: PAD_W]),
        .pad_hi  (pad_after[d*PAD_W +: PAD_W]),
        .step    (step_chain[d]),
        .at_end  (dim_end[d]),
        .in_pad  (dim_pad[d]),
        .offset  (dim_off[d])
      );
    end else begin : g_nopad
      dag_dim_counter #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .PAD_W  (PAD_W),
        .HAS_PAD(1'b0)
      ) u_dim (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .wrap_cnt(wrap[d*CNT_W +: CNT_W]),
        .stride  (stride[d*ADDR_W +: ADDR_W]),
        .pad_lo  ({PAD_W{1'b0}}),
        .pad_hi  ({PAD_W{1'b0}}),
        .step    (step_chain[d]),
        .at_end  (dim_end[d]),
        .in_pad  (dim_pad[d]),
        .offset  (dim_off[d])
      );
    end
  end

  dag_iter_ctrl #(
    .ADDR_W(ADDR_W),
    .ITER_W(ITER_W)
  ) u_iter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .base_in  (base_addr),
    .offset_in(iter_offset),
    .count_in (iter_count),
    .pass_done(pass_done),
    .pass_base(pass_base),
    .last_pass(last_pass)
  );

  // Output step composition
  always_comb begin
    out_addr = pass_base;
    for (int d = 0; d < NUM_DIMS; d++) begin
      out_addr = out_addr + dim_off[d];
    end
    out_pad   = |dim_pad[NUM_PAD_DIMS-1:0];
    out_valid = busy_q;
    busy      = busy_q;
    out_last  = busy_q && (&dim_end) && last_pass;
  end

  always_comb begin
    busy_d = busy_q;
    if (load) begin
      busy_d = 1'b1;
    end else if (fire && out_last) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end
endmodule

// File: rtl/dag_walker_chk.sv
module dag_walker_chk #(
  parameter int unsigned ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_pad,
  input logic              out_last
);
  a_r1_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy);

  a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && out_valid));

  a_r8_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_addr) && $stable(out_pad) && $stable(out_last)));

  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !busy);

  a_r10_busy_persists: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(out_valid && out_ready && out_last)) |=> busy);
endmodule

bind dag_walker dag_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_addr (out_addr),
  .out_pad  (out_pad),
  .out_last (out_last)
);

// File: tb/sim_dag_walker.sv
`timescale 1ns/1ps
module sim_dag_walker;
  localparam int AW = 20;
  localparam int CW = 10;
  localparam int PW = 4;
  localparam int IW = 8;

  typedef struct {
    logic [AW-1:0] addr;
    bit            pad;
    bit            last;
  } beat_t;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [AW-1:0] base_addr;
  logic [4*AW-1:0] stride;
  logic [4*CW-1:0] wrap;
  logic [3*PW-1:0] pad_before;
  logic [3*PW-1:0] pad_after;
  logic [IW-1:0] iter_count;
  logic [AW-1:0] iter_offset;
  logic          busy;
  logic          out_valid;
  logic          out_ready;
  logic [AW-1:0] out_addr;
  logic          out_pad;
  logic          out_last;

  int    checks;
  int    errors;
  bit    stall_mode;
  string cur_tag;
  beat_t exp_q[$];

  bit            held;
  logic [AW-1:0] held_addr;
  logic          held_pad;
  logic          held_last;

  dag_walker u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .stride(stride), .wrap(wrap), .pad_before(pad_before), .pad_after(pad_after),
    .iter_count(iter_count), .iter_offset(iter_offset), .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_pad(out_pad), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Monitor: drives ready, compares handshaken steps against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      out_ready <= stall_mode ? (($urandom % 3) != 0) : 1'b1;
      #1;
      if (held) begin
        check(out_valid && out_addr == held_addr && out_pad == held_pad &&
              out_last == held_last, "R9", "stalled step changed",
              {out_valid, out_pad, out_last, out_addr},
              {1'b1, held_pad, held_last, held_addr});
      end
      held = out_valid && !out_ready;
      held_addr = out_addr;
      held_pad  = out_pad;
      held_last = out_last;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_tag, "unexpected extra step", out_addr, 0);
        end else begin
          beat_t e;
          e = exp_q.pop_front();
          check(out_pad == e.pad, cur_tag, "pad flag", out_pad, e.pad);
          check(out_last == e.last, cur_tag, "last flag", out_last, e.last);
          if (!e.pad) begin
            check(out_addr == e.addr, cur_tag, "address", out_addr, e.addr);
          end
        end
      end
    end else begin
      out_ready <= 1'b0;
      held = 1'b0;
    end
  end

  // Build the expected step list from the pattern description
  task automatic kick(input int w[4], input int s[4], input int pb[3], input int pa[3],
                      input int n, input int base, input int ioff);
    int t0, t1, t2;
    t0 = pb[0] + w[0] + pa[0];
    t1 = pb[1] + w[1] + pa[1];
    t2 = pb[2] + w[2] + pa[2];
    for (int it = 0; it < n; it++)
      for (int p3 = 0; p3 < w[3]; p3++)
        for (int p2 = 0; p2 < t2; p2++)
          for (int p1 = 0; p1 < t1; p1++)
            for (int p0 = 0; p0 < t0; p0++) begin
              beat_t b;
              int a;
              b.pad = (p0 < pb[0]) || (p0 >= pb[0] + w[0]) ||
                      (p1 < pb[1]) || (p1 >= pb[1] + w[1]) ||
                      (p2 < pb[2]) || (p2 >= pb[2] + w[2]);
              a = base + it * ioff + (p0 - pb[0]) * s[0] + (p1 - pb[1]) * s[1] +
                  (p2 - pb[2]) * s[2] + p3 * s[3];
              b.addr = a[AW-1:0];
              b.last = (it == n - 1) && (p3 == w[3] - 1) && (p2 == t2 - 1) &&
                       (p1 == t1 - 1) && (p0 == t0 - 1);
              exp_q.push_back(b);
            end
    @(negedge clk);
    base_addr   = base[AW-1:0];
    iter_offset = ioff[AW-1:0];
    iter_count  = n[IW-1:0];
    for (int d = 0; d < 4; d++) begin
      stride[d*AW +: AW] = s[d][AW-1:0];
      wrap[d*CW +: CW]   = w[d][CW-1:0];
    end
    for (int d = 0; d < 3; d++) begin
      pad_before[d*PW +: PW] = pb[d][PW-1:0];
      pad_after[d*PW +: PW]  = pa[d][PW-1:0];
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain(input string tag);
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    #3;
    check(!busy && !out_valid, tag, "busy after final step", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; stall_mode = 0; cur_tag = "R1";
    rst_n = 1'b0; start = 1'b0;
    base_addr = '0; stride = '0; wrap = '0; pad_before = '0; pad_after = '0;
    iter_count = '0; iter_offset = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #3;
    check(!busy && !out_valid, "R1", "idle after reset", {busy, out_valid}, 0);

    // R2 R3 R8: single level, unit stride
    cur_tag = "R2/R3/R8";
    kick('{5, 1, 1, 1}, '{1, 0, 0, 0}, '{0, 0, 0}, '{0, 0, 0}, 1, 'h100, 0);
    drain("R10");

    // R4: all four levels, mixed strides including negative, with stalls (R9)
    cur_tag = "R4";
    stall_mode = 1;
    kick('{3, 2, 2, 2}, '{2, 16, -64, 1000}, '{0, 0, 0}, '{0, 0, 0}, 1, 'h2000, 0);
    drain("R10");

    // R5: repeated passes with offset, wrapping past the top of the address space
    cur_tag = "R5";
    kick('{2, 3, 1, 1}, '{1, 8, 0, 0}, '{0, 0, 0}, '{0, 0, 0}, 3, 'hFFFF0, 100);
    drain("R10");

    // R6 R7: padding on the three inner levels
    cur_tag = "R6/R7";
    stall_mode = 0;
    kick('{3, 2, 2, 2}, '{1, 10, 100, 1000}, '{2, 1, 1}, '{1, 2, 0}, 2, 'h40, 7);
    drain("R10");

    // R6: trailing pads only, with stalls
    cur_tag = "R6";
    stall_mode = 1;
    kick('{2, 1, 2, 1}, '{4, 0, 32, 0}, '{0, 0, 0}, '{3, 0, 1}, 1, 'h500, 0);
    drain("R10");

    // R10: start while busy is ignored
    cur_tag = "R10";
    kick('{4, 3, 1, 1}, '{1, 4, 0, 0}, '{0, 0, 0}, '{0, 0, 0}, 1, 'h800, 0);
    repeat (3) @(negedge clk);
    base_addr = 'h12345; wrap = '0; stride = '1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drain("R10");
    check(exp_q.size() == 0, "R10", "scoreboard empty", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule